// File: doc/BRIEF.md
# Software Reset and Reset-Output Controller

This block lets software trigger resets through a single control register and reports how the last reset ended. A write can start a full internal system reset sequence, which raises an internal reset request, or an external-only pulse, which raises only the reset-output pin. The external pulse ends by itself after a parameterised number of clocks, or at once when software writes the bit back to 0. Writing the bit to 1 again during a pulse restarts its count.

A checkstop input can also start the system reset sequence, but only while a checkstop-enable bit is set. That bit comes out of power-on reset set, and only power-on reset returns it to 1. Each time the reset output negates, the block stores two things in a status register. The first is the boot-configuration pins as they stood four clocks earlier, or zero if the reset-configuration pin is low. The second is the level of the weak-pull configuration pin. A flag records that a software external reset has taken place.

Top module: `srst_ctrl`

## Requirements
- R1: After power-on reset (`rst_ni` low), the control register at offset 0x10 reads 0x0000_8000, the status register at offset 0x00 reads 0, and `rst_out_o` and `sys_rst_o` are low.
- R2: A write to offset 0x10 with bit 31 set raises `sys_rst_o` and `rst_out_o` from the write edge for SYS_CYCLES (default 8) clocks. Bit 31 always reads 0.
- R3: A write to offset 0x10 with bit 30 set raises `rst_out_o`, but not `sys_rst_o`, from the write edge for exactly EXT_CYCLES (default 16) clocks. Bit 30 reads 1 while the pulse lasts and 0 afterwards.
- R4: A write to offset 0x10 with bit 30 clear ends an active external pulse at that edge, whatever count has elapsed. Such a write has no effect when no pulse is active.
- R5: A write with bit 30 set during an active external pulse restarts the full EXT_CYCLES count.
- R6: With bit 15 (checkstop enable) set, a high `checkstop_i` at a clock edge starts the system reset sequence from that edge. With bit 15 clear, `checkstop_i` has no effect.
- R7: Bit 15 is written from write data bit 15. Only `rst_ni` sets it back to 1. A system reset sequence leaves it unchanged.
- R8: At the edge where `rst_out_o` negates, status bits [5:4] take the value of `boot_cfg_i` sampled four edges earlier if `rst_cfg_i` is high at that edge, and 0b00 otherwise.
- R9: At each negation of `rst_out_o`, status bit 1 takes `wkp_cfg_i`. Status bit 0 is set by a write that starts an external pulse, and is cleared when a system reset sequence starts.
- R10: Reads from offsets other than 0x00 and 0x10 return 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for `addr_i`, combinational |
| checkstop_i | input | 1 | Checkstop reset request |
| boot_cfg_i | input | BOOT_W | Boot-configuration pins |
| rst_cfg_i | input | 1 | Reset-configuration pin; enables boot capture |
| wkp_cfg_i | input | 1 | Weak-pull configuration pin |
| rst_out_o | output | 1 | Reset-output pin, active high |
| sys_rst_o | output | 1 | Internal system reset request |

## Verification
Every output comes from a register that changes on the edge that samples the write or checkstop. The bench therefore checks `rst_out_o`, `sys_rst_o` and readback one time step after that edge. It then counts edges to find the last high cycle and the first low cycle of each pulse: EXT_CYCLES edges for an external pulse, SYS_CYCLES for a system sequence. Status is read after the negation edge. The expected boot field comes from a five-entry bench history of the pins, where the entry four edges before the negation gives the expected value. Cancel timing is swept across every elapsed count from 1 to 15, and boot capture across both reset-configuration levels and both weak-pull levels.

// File: rtl/srst_pkg.sv
`timescale 1ns/1ps
package srst_pkg;
  localparam int unsigned CTRL_OFF    = 32'h10;
  localparam int unsigned STAT_OFF    = 32'h00;
  localparam int unsigned SSR_BIT     = 31;
  localparam int unsigned SER_BIT     = 30;
  localparam int unsigned CRE_BIT     = 15;
  localparam int unsigned ST_SERF_BIT = 0;
  localparam int unsigned ST_WKP_BIT  = 1;
  localparam int unsigned ST_BOOT_LSB = 4;
endpackage

// File: rtl/srst_timer.sv
`timescale 1ns/1ps
module srst_timer #(
  parameter int unsigned CYCLES  = 16,
  parameter bit          RESTART = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cancel_i,
  output logic active_o,
  output logic active_nxt_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          load;

  generate
    if (RESTART) begin : g_restart
      assign load = start_i;
    end else begin : g_once
      assign load = start_i && (cnt_q == '0);
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (cancel_i)            cnt_d = '0;
    else if (load)           cnt_d = CW'(CYCLES);
    else if (cnt_q != '0)    cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign active_o     = (cnt_q != '0);
  assign active_nxt_o = (cnt_d != '0);
endmodule

// File: rtl/srst_cfg_latch.sv
`timescale 1ns/1ps
module srst_cfg_latch #(
  parameter int unsigned BOOT_W = 2,
  parameter int unsigned DELAY  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BOOT_W-1:0] boot_i,
  input  logic              rst_cfg_i,
  input  logic              wkp_i,
  input  logic              capture_i,
  output logic [BOOT_W-1:0] boot_o,
  output logic              wkp_o
);
  logic [DELAY-1:0][BOOT_W-1:0] hist_q;
  logic [BOOT_W-1:0]            boot_q;
  logic                         wkp_q;

  // hist_q[DELAY-1] holds the pins as sampled DELAY edges ago
  generate
    if (DELAY > 1) begin : g_shift
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= {hist_q[DELAY-2:0], boot_i};
      end
    end else begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q[0] <= boot_i;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q <= '0;
      wkp_q  <= 1'b0;
    end else if (capture_i) begin
      boot_q <= rst_cfg_i ? hist_q[DELAY-1] : '0;
      wkp_q  <= wkp_i;
    end
  end

  assign boot_o = boot_q;
  assign wkp_o  = wkp_q;
endmodule

// File: rtl/srst_regs.sv
`timescale 1ns/1ps
module srst_regs
  import srst_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BOOT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ser_active_i,
  input  logic              sys_start_i,
  input  logic [BOOT_W-1:0] boot_st_i,
  input  logic              wkp_st_i,
  output logic              ssr_req_o,
  output logic              ser_set_o,
  output logic              ser_clr_o,
  output logic              cre_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic ctrl_hit, stat_hit, ctrl_wr;
  logic cre_q, serf_q;

  assign ctrl_hit = (addr_i == ADDR_W'(CTRL_OFF));
  assign stat_hit = (addr_i == ADDR_W'(STAT_OFF));
  assign ctrl_wr  = wr_en_i && ctrl_hit;

  assign ssr_req_o = ctrl_wr &&  wdata_i[SSR_BIT];
  assign ser_set_o = ctrl_wr &&  wdata_i[SER_BIT];
  assign ser_clr_o = ctrl_wr && !wdata_i[SER_BIT];

  // enable bit: only the power-on reset brings it back to 1
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cre_q <= 1'b1;
    else if (ctrl_wr) cre_q <= wdata_i[CRE_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          serf_q <= 1'b0;
    else if (ser_set_o)   serf_q <= 1'b1;
    else if (sys_start_i) serf_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    if (ctrl_hit) begin
      rdata_o[SER_BIT] = ser_active_i;
      rdata_o[CRE_BIT] = cre_q;
    end else if (stat_hit) begin
      rdata_o[ST_SERF_BIT]                = serf_q;
      rdata_o[ST_WKP_BIT]                 = wkp_st_i;
      rdata_o[ST_BOOT_LSB +: BOOT_W]      = boot_st_i;
    end
  end

  assign cre_o = cre_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;
endmodule

// File: rtl/srst_ctrl.sv
`timescale 1ns/1ps
module srst_ctrl
  import srst_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned BOOT_W     = 2,
  parameter int unsigned EXT_CYCLES = 16,
  parameter int unsigned SYS_CYCLES = 8,
  parameter int unsigned BOOT_DELAY = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              checkstop_i,
  input  logic [BOOT_W-1:0] boot_cfg_i,
  input  logic              rst_cfg_i,
  input  logic              wkp_cfg_i,
  output logic              rst_out_o,
  output logic              sys_rst_o
);
  logic ssr_req, ser_set, ser_clr, cre;
  logic ser_active, ser_nxt, sys_active, sys_nxt;
  logic sys_go, sys_start, negate;
  logic [BOOT_W-1:0] boot_st;
  logic wkp_st;

  assign sys_go    = ssr_req || (checkstop_i && cre);
  assign sys_start = sys_go && !sys_active;
  // reset output drops on this edge
  assign negate    = (ser_active || sys_active) && !(ser_nxt || sys_nxt);

  srst_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BOOT_W(BOOT_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .ser_active_i (ser_active),
    .sys_start_i  (sys_start),
    .boot_st_i    (boot_st),
    .wkp_st_i     (wkp_st),
    .ssr_req_o    (ssr_req),
    .ser_set_o    (ser_set),
    .ser_clr_o    (ser_clr),
    .cre_o        (cre),
    .rdata_o      (rdata_o)
  );

  srst_timer #(.CYCLES(EXT_CYCLES), .RESTART(1'b1)) u_ext_tmr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (ser_set),
    .cancel_i     (ser_clr),
    .active_o     (ser_active),
    .active_nxt_o (ser_nxt)
  );

  srst_timer #(.CYCLES(SYS_CYCLES), .RESTART(1'b0)) u_sys_tmr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (sys_go),
    .cancel_i     (1'b0),
    .active_o     (sys_active),
    .active_nxt_o (sys_nxt)
  );

  srst_cfg_latch #(.BOOT_W(BOOT_W), .DELAY(BOOT_DELAY)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .boot_i    (boot_cfg_i),
    .rst_cfg_i (rst_cfg_i),
    .wkp_i     (wkp_cfg_i),
    .capture_i (negate),
    .boot_o    (boot_st),
    .wkp_o     (wkp_st)
  );

  assign rst_out_o = ser_active || sys_active;
  assign sys_rst_o = sys_active;
endmodule

// File: rtl/srst_ctrl_chk.sv
`timescale 1ns/1ps
module srst_ctrl_chk
  import srst_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BOOT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              checkstop_i,
  input logic [BOOT_W-1:0] boot_cfg_i,
  input logic              rst_cfg_i,
  input logic              rst_out_o,
  input logic              sys_rst_o,
  input logic              cre_i,
  input logic              ser_active_i,
  input logic [BOOT_W-1:0] boot_st_i
);
  logic       ctrl_wr;
  logic [2:0] age_q;
  logic       warm;

  assign ctrl_wr = wr_en_i && (addr_i == ADDR_W'(CTRL_OFF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end
  assign warm = (age_q >= 3'd6);

  AST_SYS_HOLDS_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |-> rst_out_o); // R2

  AST_SER_RAISES_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && wdata_i[SER_BIT]) |=> (rst_out_o && ser_active_i)); // R3

  AST_SER_CANCEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !wdata_i[SER_BIT]) |=> !ser_active_i); // R4

  AST_CS_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cre_i && !sys_rst_o && !(ctrl_wr && wdata_i[SSR_BIT])) |=> !sys_rst_o); // R6

  AST_CS_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cre_i && checkstop_i && !sys_rst_o) |=> sys_rst_o); // R6

  AST_CRE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(cre_i)); // R7

  AST_BOOT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $fell(rst_out_o)) |->
      (boot_st_i == ($past(rst_cfg_i) ? $past(boot_cfg_i, 5) : '0))); // R8
endmodule

bind srst_ctrl srst_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BOOT_W (BOOT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .checkstop_i  (checkstop_i),
  .boot_cfg_i   (boot_cfg_i),
  .rst_cfg_i    (rst_cfg_i),
  .rst_out_o    (rst_out_o),
  .sys_rst_o    (sys_rst_o),
  .cre_i        (cre),
  .ser_active_i (ser_active),
  .boot_st_i    (boot_st)
);

// File: tb/tb_srst_ctrl.sv
`timescale 1ns/1ps
module tb_srst_ctrl;
  localparam int EXT = 16;
  localparam int SYS = 8;
  localparam logic [7:0]  CTRL = 8'h10;
  localparam logic [7:0]  STAT = 8'h00;
  localparam logic [31:0] SSR  = 32'h8000_0000;
  localparam logic [31:0] SER  = 32'h4000_0000;
  localparam logic [31:0] CRE  = 32'h0000_8000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        checkstop_i = 1'b0;
  logic [1:0]  boot_cfg_i = '0;
  logic        rst_cfg_i = 1'b0;
  logic        wkp_cfg_i = 1'b0;
  logic        rst_out_o, sys_rst_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  logic [1:0] bh [5];
  logic [31:0] d;

  always #2.5 clk = ~clk;

  srst_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .checkstop_i(checkstop_i),
    .boot_cfg_i(boot_cfg_i), .rst_cfg_i(rst_cfg_i), .wkp_cfg_i(wkp_cfg_i),
    .rst_out_o(rst_out_o), .sys_rst_o(sys_rst_o)
  );

  // pin history as seen at each edge; bh[4] is four edges before bh[0]
  always @(posedge clk) begin
    for (int i = 4; i > 0; i--) bh[i] <= bh[i-1];
    bh[0] <= boot_cfg_i;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    cyc++;
    boot_cfg_i = 2'(cyc ^ (cyc >> 2));
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr_i = a;
    #0.5;
    v = rdata_o;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    wr_en_i = 1'b1;
    addr_i  = a;
    wdata_i = v;
    tick();
    wr_en_i = 1'b0;
    wdata_i = '0;
  endtask

  function automatic logic [31:0] stat(input logic serf, input logic wkp, input logic [1:0] boot);
    return {26'b0, boot, 2'b0, wkp, serf};
  endfunction

  initial begin
    for (int i = 0; i < 5; i++) bh[i] = '0;
    repeat (3) tick();
    rst_ni = 1'b1;
    // R1 reset state
    chk("R1 rst_out", 32'(rst_out_o), 0);
    chk("R1 sys_rst", 32'(sys_rst_o), 0);
    rd(CTRL, d); chk("R1 ctrl", d, CRE);
    rd(STAT, d); chk("R1 stat", d, 0);
    tick();

    // R3 full external pulse, R8/R9 capture over cfg and weak-pull levels
    for (int rc = 0; rc < 2; rc++) begin
      for (int wk = 0; wk < 2; wk++) begin
        rst_cfg_i = rc[0];
        wkp_cfg_i = wk[0];
        wr(CTRL, SER | CRE);
        chk("R3 pin up", 32'(rst_out_o), 1);
        chk("R3 sys quiet", 32'(sys_rst_o), 0);
        rd(CTRL, d); chk("R3 ser reads 1", d, SER | CRE);
        for (int n = 1; n < EXT; n++) begin
          tick();
          chk("R3 pin held", 32'(rst_out_o), 1);
        end
        tick();
        chk("R3 pin down", 32'(rst_out_o), 0);
        rd(CTRL, d); chk("R3 ser reads 0", d, CRE);
        rd(STAT, d);
        chk("R8 R9 capture", d, stat(1'b1, wk[0], rc[0] ? bh[4] : 2'b00));
        tick();
      end
    end

    // R4 cancel at every elapsed count
    rst_cfg_i = 1'b1;
    wkp_cfg_i = 1'b0;
    for (int k = 1; k < EXT; k++) begin
      wr(CTRL, SER | CRE);
      repeat (k - 1) tick();
      chk("R4 pin before cancel", 32'(rst_out_o), 1);
      wr(CTRL, CRE);
      chk("R4 pin cancelled", 32'(rst_out_o), 0);
      rd(STAT, d); chk("R8 boot at cancel", d, stat(1'b1, 1'b0, bh[4]));
      tick();
    end
    wr(CTRL, CRE);
    chk("R4 idle clear", 32'(rst_out_o), 0);

    // R5 restart
    wr(CTRL, SER | CRE);
    repeat (9) tick();
    wr(CTRL, SER | CRE);
    repeat (EXT - 1) tick();
    chk("R5 still high after restart", 32'(rst_out_o), 1);
    tick();
    chk("R5 low after restart", 32'(rst_out_o), 0);

    // R2 software system reset, R9 flag clear
    rst_cfg_i = 1'b0;
    wkp_cfg_i = 1'b1;
    wr(CTRL, SSR | CRE);
    chk("R2 sys up", 32'(sys_rst_o), 1);
    chk("R2 pin up", 32'(rst_out_o), 1);
    rd(CTRL, d); chk("R2 ssr reads 0", d, CRE);
    repeat (SYS - 1) tick();
    chk("R2 sys held", 32'(sys_rst_o), 1);
    tick();
    chk("R2 sys down", 32'(sys_rst_o), 0);
    chk("R2 pin down", 32'(rst_out_o), 0);
    rd(STAT, d); chk("R9 flag cleared wkp latched R8 boot zero", d, stat(1'b0, 1'b1, 2'b00));
    rd(CTRL, d); chk("R7 enable kept", d, CRE);

    // R6 checkstop gating
    wr(CTRL, 32'h0);
    rd(CTRL, d); chk("R7 enable written 0", d, 0);
    checkstop_i = 1'b1;
    repeat (3) begin
      tick();
      chk("R6 masked", 32'(sys_rst_o), 0);
    end
    checkstop_i = 1'b0;
    wr(CTRL, CRE);
    wr(CTRL, SER | CRE);
    checkstop_i = 1'b1;
    tick();
    checkstop_i = 1'b0;
    chk("R6 taken", 32'(sys_rst_o), 1);
    repeat (SYS - 1) tick();
    chk("R6 held", 32'(sys_rst_o), 1);
    tick();
    chk("R6 done", 32'(sys_rst_o), 0);
    rd(STAT, d); chk("R9 flag cleared by checkstop", d[0], 0);
    tick();

    // R7 enable retained through system reset, restored by power-on
    wr(CTRL, SSR);
    repeat (SYS) tick();
    rd(CTRL, d); chk("R7 enable stays 0", d, 0);
    rst_ni = 1'b0;
    tick();
    rst_ni = 1'b1;
    rd(CTRL, d); chk("R7 power-on sets enable", d, CRE);
    rd(STAT, d); chk("R1 stat after power-on", d, 0);
    tick();

    // R10 unmapped offsets
    rd(8'h04, d); chk("R10 read 0x04", d, 0);
    rd(8'h14, d); chk("R10 read 0x14", d, 0);
    wr(8'h14, SSR | SER);
    chk("R10 write ignored pin", 32'(rst_out_o), 0);
    rd(CTRL, d); chk("R10 write ignored ctrl", d, CRE);
    tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule